// File: doc/BRIEF.md
# Hot-Swap Rail Sequencing Controller

This block drives the enable outputs of four power rails on a plug-in card: +12V, +5V, +3.3V and -12V. A card-absent input must be low before any rail may turn on. A power command pin turns the rails on with its rising edge and off with its falling edge. A write strobe with a request mask sets the per-rail request bits directly. An order-mode bit decides how the rails come up. With the bit set, the rails come up one after another. With it clear, the requested rails come up together. After power-up the block holds every rail off for a fixed boot delay.

A shared window timer measures four windows in clock ticks: the boot delay, a start-up window after each turn-on, a power-good window, and an auto-retry window. The power-good and auto-retry windows are 10 and 50 times the start-up window. Each rail has an overcurrent comparator flag that feeds a persistence filter. The filter is armed only once the rail's start-up window has ended, so it acts as a circuit breaker. An external power-good input is sampled when the power-good window ends. After that the input is monitored continuously through its own filter. Any fault drops every rail. A fault stays latched until the command pin or the card-absent input falls, or until an auto-retry window expires.

All inputs are taken to be synchronous to `clk`. The block has no data stream, so every pin is a plain level or strobe.

Top module: `rail_seq_ctrl`

## Requirements
- R1: While `card_absent` is high, `rail_en` is 0 from the next cycle on.
- R2: After boot, a rising edge on `pwr_cmd` sets the request bits. With `order_mode` = 1 it sets all four bits (4'hF). With `order_mode` = 0 it sets only bit 0 (+12V). A falling edge clears every request bit, so all rails go off.
- R3: `rail_en` stays 0 for `BOOT_US`·`TICK_PER_US` cycles after reset. If `pwr_cmd` is high when that delay ends, the request bits are set exactly as a rising edge sets them.
- R4: With `order_mode` = 1, rails turn on one at a time in bit order: bit 0 = +12V, bit 1 = +5V, bit 2 = +3.3V, bit 3 = -12V. Each rail is enabled only after the previous rail's start-up window of `START_TICKS` cycles has ended, so successive enables are START_TICKS+1 cycles apart.
- R5: With `order_mode` = 0, all requested rails that are not yet on are enabled in the same cycle. A `req_wr` strobe loads `req_bits` into the request bits.
- R6: An `oc_hit[i]` flag raised during rail i's start-up window sets no fault and does not disturb the rail.
- R7: Once rail i is past its start-up window, `oc_hit[i]` held high for `TRIP_US`·`TICK_PER_US` consecutive cycles sets `oc_fault[i]` and turns every rail off. A shorter pulse has no effect.
- R8: After all requested rails are on and their start-up window has ended, a window of 10·`START_TICKS` cycles runs. If `ext_pgood` is low when it ends, `pg_fault` is set and every rail turns off. If it is high, the rails stay on.
- R9: After a passed power-good window, with `pg_mon_off` = 0, `ext_pgood` low for more than `PG_FILT_US`·`TICK_PER_US` cycles sets `pg_fault` and turns every rail off. A shorter low pulse, or any low time while `pg_mon_off` = 1, has no effect.
- R10: While any fault is latched, `rail_en` is 0. A falling edge on `pwr_cmd` or on `card_absent` clears all faults.
- R11: With `auto_retry` = 1, a latched fault with every rail off starts a window of 50·`START_TICKS` cycles. When that window ends, the faults clear and the requested rails power up again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| card_absent | input | 1 | High while the card is not seated; forces all rails off |
| pwr_cmd | input | 1 | Power command pin; rising edge turns on, falling edge turns off |
| order_mode | input | 1 | 1 = ordered one-at-a-time turn-on |
| req_wr | input | 1 | Strobe that loads `req_bits` into the request bits |
| req_bits | input | 4 | Per-rail request mask (bit 0 +12V … bit 3 -12V) |
| pg_mon_off | input | 1 | 1 = ignore `ext_pgood` during normal running |
| auto_retry | input | 1 | 1 = clear faults automatically after the retry window |
| oc_hit | input | 4 | Per-rail overcurrent comparator flags |
| ext_pgood | input | 1 | External power-good input |
| rail_en | output | 4 | Rail enable outputs |
| oc_fault | output | 4 | Latched per-rail breaker trip bits |
| pg_fault | output | 1 | Latched power-good fault |

## Verification
On every cycle the assertions check four things. A seated-card violation or a breaker trip empties `rail_en` on the next cycle. A latched fault coincides with all rails off. Ordered mode never adds more than one rail per cycle. Below them, the timer frees itself after each window, and a filter trip always follows a held, armed level. The bench's scenarios are the only place the time-based behaviour shows. That covers the boot delay, the START_TICKS+1 spacing between ordered rails, and the ignored flag during a start-up window. It also covers the difference between a short and a long overcurrent pulse, the end-of-window power-good sample, the monitor-off bit, and the retry window length.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int RAILS = 4;

  typedef enum logic [1:0] {
    TM_BOOT  = 2'd0,
    TM_START = 2'd1,
    TM_PG    = 2'd2,
    TM_RETRY = 2'd3
  } tmode_e;

  // isolate the lowest set bit of a rail mask
  function automatic logic [RAILS-1:0] lowest_bit(input logic [RAILS-1:0] m);
    return m & (~m + RAILS'(1));
  endfunction
endpackage

// File: rtl/rsc_window_timer.sv
module rsc_window_timer
  import rsc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] len_i,
  input  tmode_e       mode_i,
  input  logic         abort_i,
  output logic         busy_o,
  output tmode_e       mode_o,
  output logic         done_o
);
  logic [W-1:0] cnt_q;
  logic         busy_q;
  tmode_e       mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      mode_q <= TM_BOOT;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= len_i;
      mode_q <= mode_i;
    end else if (busy_q) begin
      cnt_q <= cnt_q - W'(1);
      if (abort_i || cnt_q == W'(1)) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign mode_o = mode_q;
  assign done_o = busy_q && (cnt_q == W'(1));

  // R4
  window_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> !busy_o);
endmodule

// File: rtl/rsc_persist.sv
module rsc_persist #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic level_i,
  output logic trip_o
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (!(arm_i && level_i)) cnt_q <= '0;
    else if (cnt_q != CW'(LEN - 1)) cnt_q <= cnt_q + CW'(1);
  end

  assign trip_o = arm_i && level_i && (cnt_q == CW'(LEN - 1));

  // R7
  held_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_o |-> ($past(level_i) && $past(arm_i)));
endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
  import rsc_pkg::*;
#(
  parameter int TICK_PER_US = 250,
  parameter int BOOT_US     = 100000,
  parameter int START_TICKS = 2500,
  parameter int TRIP_US     = 22,
  parameter int PG_FILT_US  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             card_absent,
  input  logic             pwr_cmd,
  input  logic             order_mode,
  input  logic             req_wr,
  input  logic [RAILS-1:0] req_bits,
  input  logic             pg_mon_off,
  input  logic             auto_retry,
  input  logic [RAILS-1:0] oc_hit,
  input  logic             ext_pgood,
  output logic [RAILS-1:0] rail_en,
  output logic [RAILS-1:0] oc_fault,
  output logic             pg_fault
);
  localparam int PG_TICKS    = 10 * START_TICKS;
  localparam int RETRY_TICKS = 50 * START_TICKS;
  localparam int BOOT_TICKS  = BOOT_US * TICK_PER_US;
  localparam int TRIP_TICKS  = TRIP_US * TICK_PER_US;
  localparam int PGF_TICKS   = PG_FILT_US * TICK_PER_US;
  localparam int LONGEST     = (BOOT_TICKS > RETRY_TICKS) ? BOOT_TICKS : RETRY_TICKS;
  localparam int TW          = $clog2(LONGEST + 1);
  localparam logic [RAILS-1:0] ALL = '1;

  logic             boot_q, cmd_q, absent_q, pg_run_q, pg_fault_q;
  logic [RAILS-1:0] req_q, en_q, arm_q, oc_fault_q;

  // timer wiring
  logic          t_start, t_abort, tm_busy, tm_done;
  logic [TW-1:0] t_len;
  tmode_e        t_mode, tm_mode;

  rsc_window_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start_i(t_start), .len_i(t_len), .mode_i(t_mode),
    .abort_i(t_abort), .busy_o(tm_busy), .mode_o(tm_mode), .done_o(tm_done)
  );

  // per-rail breakers
  logic [RAILS-1:0] trips;
  for (genvar i = 0; i < RAILS; i++) begin : g_cb
    rsc_persist #(.LEN(TRIP_TICKS)) u_cb (
      .clk(clk), .rst_n(rst_n), .arm_i(arm_q[i] & en_q[i]),
      .level_i(oc_hit[i]), .trip_o(trips[i])
    );
  end

  // running power-good monitor (must exceed the filter time)
  logic pg_trip;
  rsc_persist #(.LEN(PGF_TICKS + 1)) u_pgf (
    .clk(clk), .rst_n(rst_n), .arm_i(pg_run_q & ~pg_mon_off & (|en_q)),
    .level_i(~ext_pgood), .trip_o(pg_trip)
  );

  // events
  logic cmd_rise, cmd_fall, card_fall, clr_evt, boot_end, pg_end, start_end, retry_end;
  assign cmd_rise  = pwr_cmd & ~cmd_q & ~boot_q;
  assign cmd_fall  = ~pwr_cmd & cmd_q;
  assign card_fall = ~card_absent & absent_q;
  assign boot_end  = tm_done && tm_mode == TM_BOOT;
  assign start_end = tm_done && tm_mode == TM_START;
  assign pg_end    = tm_done && tm_mode == TM_PG;
  assign retry_end = tm_done && tm_mode == TM_RETRY;
  assign clr_evt   = cmd_fall | card_fall | retry_end;

  logic [RAILS-1:0] oc_fault_n, req_n, target, en_n, arm_n, need;
  logic             pg_fault_n, fault_now, drop, pg_run_n;

  always_comb begin
    oc_fault_n = (clr_evt ? '0 : oc_fault_q) | trips;
    pg_fault_n = (clr_evt ? 1'b0 : pg_fault_q) | pg_trip | (pg_end & ~ext_pgood);
    fault_now  = (|oc_fault_n) | pg_fault_n;

    req_n = req_q;
    if (cmd_fall)                          req_n = '0;
    else if (cmd_rise || (boot_end && pwr_cmd)) req_n = order_mode ? ALL : RAILS'(1);
    else if (req_wr)                       req_n = req_bits;

    target = (!boot_q && !card_absent && !fault_now) ? req_q : '0;
    need   = target & ~en_q;
    drop   = |(en_q & ~target);
    en_n   = en_q & target;

    t_start = 1'b0;
    t_len   = TW'(START_TICKS);
    t_mode  = TM_START;
    t_abort = tm_busy && ((drop && (tm_mode == TM_START || tm_mode == TM_PG)) ||
                          (tm_mode == TM_RETRY && !fault_now));

    if (boot_q) begin
      if (!tm_busy) begin
        t_start = 1'b1;
        t_len   = TW'(BOOT_TICKS);
        t_mode  = TM_BOOT;
      end
    end else if (!drop && !tm_busy) begin
      if (fault_now) begin
        if (auto_retry && en_q == '0) begin
          t_start = 1'b1;
          t_len   = TW'(RETRY_TICKS);
          t_mode  = TM_RETRY;
        end
      end else if (need != '0) begin
        en_n    = en_q | (order_mode ? lowest_bit(need) : need);
        t_start = 1'b1;
      end else if (en_q != '0 && !pg_run_q) begin
        t_start = 1'b1;
        t_len   = TW'(PG_TICKS);
        t_mode  = TM_PG;
      end
    end

    arm_n    = (arm_q | (start_end ? en_q : '0)) & en_n;
    pg_run_n = (drop || en_n == '0) ? 1'b0 : (pg_run_q | (pg_end & ext_pgood));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q     <= 1'b1;
      cmd_q      <= 1'b0;
      absent_q   <= 1'b1;
      req_q      <= '0;
      en_q       <= '0;
      arm_q      <= '0;
      oc_fault_q <= '0;
      pg_fault_q <= 1'b0;
      pg_run_q   <= 1'b0;
    end else begin
      boot_q     <= boot_q & ~boot_end;
      cmd_q      <= pwr_cmd;
      absent_q   <= card_absent;
      req_q      <= req_n;
      en_q       <= en_n;
      arm_q      <= arm_n;
      oc_fault_q <= oc_fault_n;
      pg_fault_q <= pg_fault_n;
      pg_run_q   <= pg_run_n;
    end
  end

  assign rail_en  = en_q;
  assign oc_fault = oc_fault_q;
  assign pg_fault = pg_fault_q;

  // R1
  card_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_absent |=> rail_en == '0);

  // R4
  one_rail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    order_mode |=> $countones(rail_en & ~$past(rail_en)) <= 1);

  // R7
  trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|trips) |=> (rail_en == '0) && (oc_fault != '0));

  // R10
  fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|oc_fault) || pg_fault) |-> rail_en == '0);
endmodule

// File: tb/rail_seq_ctrl_tb.sv
module rail_seq_ctrl_tb;
  localparam int TPU = 4, BOOTU = 50, ST = 120, TRIPU = 22, PGFU = 20;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       card_absent, pwr_cmd, order_mode, req_wr, pg_mon_off, auto_retry, ext_pgood;
  logic [3:0] req_bits, oc_hit, rail_en, oc_fault;
  logic       pg_fault;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  rail_seq_ctrl #(.TICK_PER_US(TPU), .BOOT_US(BOOTU), .START_TICKS(ST),
                  .TRIP_US(TRIPU), .PG_FILT_US(PGFU)) u_dut (
    .clk(clk), .rst_n(rst_n), .card_absent(card_absent), .pwr_cmd(pwr_cmd),
    .order_mode(order_mode), .req_wr(req_wr), .req_bits(req_bits),
    .pg_mon_off(pg_mon_off), .auto_retry(auto_retry), .oc_hit(oc_hit),
    .ext_pgood(ext_pgood), .rail_en(rail_en), .oc_fault(oc_fault), .pg_fault(pg_fault)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic wait_en(input logic [3:0] m, input int lim, output int n);
    n = 0;
    while (rail_en !== m && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    cyc(1);
    chk("R3", "rail_en after reset", rail_en, 0);
    chk("R10", "oc_fault after reset", oc_fault, 0);
    chk("R8", "pg_fault after reset", pg_fault, 0);
  endtask

  // ordered boot with command pin tied high; flag during start-up window
  task automatic t_boot_order();
    int n;
    cyc(185);
    chk("R3", "rail_en during boot delay", rail_en, 0);
    wait_en(4'h1, 40, n);
    chk("R3", "+12V on after boot", rail_en, 1);
    oc_hit[0] = 1'b1;
    cyc(100);
    oc_hit[0] = 1'b0;
    chk("R6", "no trip in start-up window", oc_fault, 0);
    chk("R6", "rail held during window", rail_en, 1);
    wait_en(4'h3, 40, n);
    chk("R4", "+5V second", rail_en, 4'h3);
    chk("R4", "+5V spacing ok", int'((100 + n) >= ST - 2 && (100 + n) <= ST + 4), 1);
    wait_en(4'h7, ST + 10, n);
    chk("R4", "+3.3V third", rail_en, 4'h7);
    chk("R4", "+3.3V spacing ok", int'(n >= ST - 2 && n <= ST + 4), 1);
    wait_en(4'hF, ST + 10, n);
    chk("R4", "-12V last", rail_en, 4'hF);
    chk("R4", "-12V spacing ok", int'(n >= ST - 2 && n <= ST + 4), 1);
  endtask

  task automatic t_pg_pass();
    cyc(1500);
    chk("R8", "rails kept with good input", rail_en, 4'hF);
    chk("R8", "no pg fault", pg_fault, 0);
  endtask

  task automatic t_breaker();
    oc_hit[2] = 1'b1;
    cyc(60);
    oc_hit[2] = 1'b0;
    cyc(5);
    chk("R7", "short pulse no fault", oc_fault, 0);
    chk("R7", "short pulse rails on", rail_en, 4'hF);
    oc_hit[2] = 1'b1;
    cyc(100);
    chk("R7", "long pulse fault bit", oc_fault, 4'h4);
    chk("R7", "long pulse rails off", rail_en, 0);
    oc_hit[2] = 1'b0;
    cyc(300);
    chk("R10", "fault latched without retry", oc_fault, 4'h4);
    chk("R10", "rails held off", rail_en, 0);
  endtask

  task automatic t_cmd_edges();
    int bad = 0;
    pwr_cmd = 1'b0;
    cyc(3);
    chk("R10", "cmd fall clears faults", oc_fault, 0);
    cyc(10);
    chk("R2", "cmd fall keeps rails off", rail_en, 0);
    order_mode = 1'b0;
    pwr_cmd = 1'b1;
    cyc(4);
    chk("R2", "cmd rise unordered gives +12V only", rail_en, 1);
    req_bits = 4'hF;
    req_wr = 1'b1;
    cyc(1);
    req_wr = 1'b0;
    for (int k = 0; k < 200; k++) begin
      if (rail_en !== 4'h1 && rail_en !== 4'hF) bad++;
      cyc(1);
    end
    chk("R5", "rest of rails together", rail_en, 4'hF);
    chk("R5", "no partial steps", bad, 0);
  endtask

  task automatic t_pg_window_fail();
    int n;
    card_absent = 1'b1;
    cyc(2);
    chk("R1", "card absent drops rails", rail_en, 0);
    ext_pgood = 1'b0;
    cyc(5);
    card_absent = 1'b0;
    wait_en(4'hF, 10, n);
    chk("R5", "all rails at once", rail_en, 4'hF);
    cyc(1000);
    chk("R8", "rails on inside window", rail_en, 4'hF);
    chk("R8", "no fault inside window", pg_fault, 0);
    n = 0;
    while (!pg_fault && n < 600) begin
      cyc(1);
      n++;
    end
    chk("R8", "fault at window end", pg_fault, 1);
    cyc(2);
    chk("R8", "rails off after bad sample", rail_en, 0);
  endtask

  task automatic t_retry();
    int n;
    ext_pgood = 1'b1;
    auto_retry = 1'b1;
    cyc(5000);
    chk("R11", "still off before retry end", rail_en, 0);
    chk("R11", "fault held before retry end", pg_fault, 1);
    wait_en(4'hF, 2000, n);
    chk("R11", "rails back after retry", rail_en, 4'hF);
    chk("R11", "fault cleared by retry", pg_fault, 0);
    auto_retry = 1'b0;
  endtask

  task automatic t_run_pg();
    cyc(1500);
    pg_mon_off = 1'b1;
    ext_pgood = 1'b0;
    cyc(150);
    chk("R9", "monitor off ignores low", pg_fault, 0);
    chk("R9", "monitor off rails on", rail_en, 4'hF);
    ext_pgood = 1'b1;
    cyc(2);
    pg_mon_off = 1'b0;
    ext_pgood = 1'b0;
    cyc(50);
    ext_pgood = 1'b1;
    cyc(3);
    chk("R9", "short low no fault", pg_fault, 0);
    ext_pgood = 1'b0;
    cyc(100);
    chk("R9", "long low fault", pg_fault, 1);
    chk("R9", "long low rails off", rail_en, 0);
    ext_pgood = 1'b1;
  endtask

  task automatic t_card_clear();
    card_absent = 1'b1;
    cyc(3);
    chk("R10", "fault kept while absent", pg_fault, 1);
    card_absent = 1'b0;
    cyc(2);
    chk("R10", "card fall clears fault", pg_fault, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    card_absent = 1'b0; pwr_cmd = 1'b1; order_mode = 1'b1; req_wr = 1'b0;
    req_bits = 4'h0; pg_mon_off = 1'b0; auto_retry = 1'b0; oc_hit = 4'h0;
    ext_pgood = 1'b1;
    cyc(5);
    rst_n = 1'b1;
    t_reset();
    t_boot_order();
    t_pg_pass();
    t_breaker();
    t_cmd_edges();
    t_pg_window_fail();
    t_retry();
    t_run_pg();
    t_card_clear();
    summary();
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end
endmodule